// File: doc/BRIEF.md
# Dual-clock show-ahead FIFO

A buffer that carries words from one clock domain to a second, unrelated one. The producer side has a data input, a write enable and a full flag, all on the write clock. The consumer side has a read enable, an empty flag and a data output, all on the read clock. The oldest stored word is always visible on the data output without asking for it. A read enable consumes that word, and the next one appears at once.

Width and depth are parameters. Depth does not have to be a power of two. The positions of the two sides are exchanged between the domains as Gray-coded counts over a sequence of 2×depth codes, so only one bit changes per step, including at the wrap. Full is computed on the write side and empty on the read side. Each flag may stay asserted for a few cycles after the other side has moved, but it is never released early. A single active-low asynchronous reset clears both sides.

Top module: `xfifo_fwft`

## Requirements
- R1: While reset is low and right after it, empty_o is 1 and full_o is 0.
- R2: A word written into an empty buffer appears on rdata_o, and empty_o falls, within a few read-clock cycles and with ren_i held low.
- R3: With the default DEPTH of 5, five writes into an empty buffer raise full_o and four writes do not.
- R4: A write issued while full_o is 1 is discarded, and the discarded word is never returned by a later read.
- R5: A read issued while empty_o is 1 has no effect. A write and a read issued together on an empty buffer store only the write, and that word stays stored.
- R6: A write and a read issued together on a full buffer perform only the read. The offered word is not stored.
- R7: On a partly filled buffer, a write and a read issued together both take effect.
- R8: Words leave in write order, and after each accepted read rdata_o shows the next oldest word.
- R9: The exchanged pointer codes change by at most one bit per clock, including at the wrap of a non-power-of-two depth.
- R10: The behaviour above holds both when the read clock is faster than the write clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset for both sides, active low |
| wdata_i | input | WIDTH | Word to store |
| wen_i | input | 1 | Write request, sampled on wclk_i |
| full_o | output | 1 | No free entry (write domain) |
| ren_i | input | 1 | Consume the head word, sampled on rclk_i |
| rdata_o | output | WIDTH | Head word, valid while empty_o is 0 |
| empty_o | output | 1 | No stored word (read domain) |

## Verification
A write and a read can land in the same interval on the two clocks. The outcome then depends on which flag still holds, so this is the critical overlap. The bench issues both requests together, started from both clocks at once, with the buffer empty, full and partly filled. It then lets both flags settle and compares occupancy, flags and the head word with a reference queue. Under that queue, only the write survives on empty, only the read survives on full, and both survive otherwise. The whole sequence, including a biased random walk through all fill levels, is run once with a fast read clock and once with a slow one.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/xfifo_ptr.sv
module xfifo_ptr
  import xfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned PW    = $clog2(DEPTH) + 1,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] cnt_o,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] gray_o
);
  localparam int unsigned LAST = 2 * DEPTH - 1;
  // centre the 2*DEPTH window on the reflection point so the wrap flips only the MSB
  localparam int unsigned OFF  = (1 << (PW - 1)) - DEPTH;

  logic [PW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (inc_i) cnt_d = (cnt_o == PW'(LAST)) ? '0 : cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      gray_o <= PW'(bin2gray(32'(OFF)));
    end else begin
      cnt_o  <= cnt_d;
      gray_o <= PW'(bin2gray(32'(cnt_d) + 32'(OFF)));
    end
  end

  always_comb
    addr_o = (cnt_o >= PW'(DEPTH)) ? AW'(cnt_o - PW'(DEPTH)) : AW'(cnt_o);
endmodule

// File: rtl/xfifo_fwft.sv
module xfifo_fwft
  import xfifo_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 5
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wen_i,
  output logic             full_o,
  input  logic             ren_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);
  localparam int unsigned PW  = $clog2(DEPTH) + 1;
  localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OFF = (1 << (PW - 1)) - DEPTH;
  localparam logic [PW-1:0] RST_GRAY = PW'(bin2gray(32'(OFF)));
  localparam logic [PW:0]   TWO_D    = (PW+1)'(2 * DEPTH);

  logic          wr_ok, rd_ok;
  logic [PW-1:0] wr_cnt, rd_cnt, wr_gray, rd_gray;
  logic [PW-1:0] rg_sync, wg_sync, rs_cnt, ws_cnt;
  logic [AW-1:0] waddr, raddr;
  logic [PW:0]   fill_w;
  logic [WIDTH-1:0] mem_q [DEPTH];

  assign wr_ok = wen_i & ~full_o;
  assign rd_ok = ren_i & ~empty_o;

  xfifo_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_wptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .inc_i(wr_ok),
    .cnt_o(wr_cnt), .addr_o(waddr), .gray_o(wr_gray));

  xfifo_ptr #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rst_ni), .inc_i(rd_ok),
    .cnt_o(rd_cnt), .addr_o(raddr), .gray_o(rd_gray));

  xfifo_sync #(.W(PW), .RST_VAL(RST_GRAY)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rg_sync));

  xfifo_sync #(.W(PW), .RST_VAL(RST_GRAY)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wg_sync));

  assign rs_cnt = PW'(gray2bin(32'(rg_sync)) - 32'(OFF));
  assign ws_cnt = PW'(gray2bin(32'(wg_sync)) - 32'(OFF));

  // occupancy seen by the writer, modulo 2*DEPTH
  always_comb begin
    fill_w = {1'b0, wr_cnt} + TWO_D - {1'b0, rs_cnt};
    if (fill_w >= TWO_D) fill_w = fill_w - TWO_D;
  end

  assign full_o  = (fill_w == (PW+1)'(DEPTH));
  assign empty_o = (rd_cnt == ws_cnt);

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem_q[waddr] <= wdata_i;
  end

  // head entry was written at least two read clocks ago, so it is stable here
  assign rdata_o = mem_q[raddr];
endmodule

// File: rtl/xfifo_fwft_chk.sv
module xfifo_fwft_chk #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned PW    = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          full_o,
  input logic          empty_o,
  input logic [PW-1:0] wr_cnt,
  input logic [PW-1:0] rd_cnt,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray
);
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wen_i) |=> $stable(wr_cnt)); // R4
  AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && ren_i) |=> $stable(rd_cnt)); // R5
  AST_WRITE_ADVANCES: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen_i && !full_o) |=> !$stable(wr_cnt)); // R7
  AST_READ_ADVANCES: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren_i && !empty_o) |=> !$stable(rd_cnt)); // R8
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wr_gray ^ $past(wr_gray))); // R9
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rd_gray ^ $past(rd_gray))); // R9
endmodule

bind xfifo_fwft xfifo_fwft_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wen_i(wen_i), .ren_i(ren_i), .full_o(full_o), .empty_o(empty_o),
  .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .wr_gray(wr_gray), .rd_gray(rd_gray));

// File: tb/xfifo_fwft_test.sv
`timescale 1ns/1ps
module xfifo_fwft_test;
  localparam int W = 16;
  localparam int D = 5;

  logic wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  realtime rhalf = 2.0;
  logic [W-1:0] wdata = '0, rdata;
  logic wen = 1'b0, ren = 1'b0, full, empty;

  always #5 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  xfifo_fwft #(.WIDTH(W), .DEPTH(D)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .wdata_i(wdata),
    .wen_i(wen), .full_o(full), .ren_i(ren), .rdata_o(rdata), .empty_o(empty));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic verify(input string tag);
    chk($sformatf("%s full", tag), 32'(full), 32'(q.size() == D));
    chk($sformatf("%s empty", tag), 32'(empty), 32'(q.size() == 0));
    if (q.size() > 0) chk($sformatf("%s head", tag), 32'(rdata), 32'(q[0]));
  endtask

  task automatic wr(input logic [W-1:0] v);
    @(negedge wclk); wen = 1'b1; wdata = v;
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
  endtask

  task automatic op_wr(input logic [W-1:0] v, input string tag);
    if (q.size() < D) q.push_back(v);
    wr(v); settle(); verify(tag);
  endtask

  task automatic op_rd(input string tag);
    if (q.size() > 0) void'(q.pop_front());
    rd(); settle(); verify(tag);
  endtask

  task automatic op_both(input logic [W-1:0] v, input string tag);
    bit can_w = (q.size() < D);
    bit can_r = (q.size() > 0);
    if (can_r) void'(q.pop_front());
    if (can_w) q.push_back(v);
    fork
      wr(v);
      rd();
    join
    settle(); verify(tag);
  endtask

  initial begin
    for (int pass = 0; pass < 2; pass++) begin
      rhalf = (pass == 0) ? 2.0 : 7.0;  // read clock faster, then slower
      rst_ni = 1'b0; wen = 1'b0; ren = 1'b0;
      q.delete();
      #40;
      chk("R1 empty in reset", 32'(empty), 32'd1);
      chk("R1 full in reset", 32'(full), 32'd0);
      rst_ni = 1'b1;
      settle();
      verify("R1 after reset");

      op_wr(16'h0005, "R2 show-ahead");
      op_rd("R8 pop last");
      op_rd("R5 read on empty");
      for (int i = 0; i < D - 1; i++) op_wr(16'(10 + i), "R3 filling");
      chk("R3 not full at D-1", 32'(full), 32'd0);
      op_wr(16'd14, "R3 fill to D");
      chk("R3 full at D", 32'(full), 32'd1);
      op_wr(16'hdead, "R4 write on full");
      op_both(16'd88, "R6 both on full");
      op_wr(16'd15, "R3 refill");
      while (q.size() > 0) op_rd("R8 drain");
      op_both(16'd67, "R5 both on empty");
      op_both(16'd2, "R7 both on partial");
      op_wr(16'd3, "R7 setup");
      op_both(16'd4, "R7 both on partial");

      for (int n = 0; n < 160; n++) begin
        int unsigned r = $urandom_range(0, 3);
        logic [W-1:0] v = 16'($urandom_range(0, 65535));
        bit fill = ((n / 20) % 2) == 0;
        if (r == 3) op_both(v, "R7 random both");
        else if ((r < 2) == fill) op_wr(v, "R8 random write");
        else op_rd("R8 random read");
      end
      while (q.size() > 0) op_rd("R8 final drain");
      chk($sformatf("R10 drained pass %0d", pass), 32'(empty), 32'd1);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule